// File: doc/BRIEF.md
# Linked-Descriptor Card DMA Engine

This block moves a programmed number of bytes between system memory and a 32-bit card data port. It walks a list of descriptors held in memory. Each descriptor is four 32-bit words. The engine fetches a descriptor through a single-word memory port. It then streams the descriptor's buffer one word at a time, either from memory to the card or from the card to memory. After the data it writes the descriptor's status word back with the ownership bit cleared. It then either follows the next pointer or stops.

Software loads a base address, a byte count, a block size, an enable and a direction, and then pulses `start`. When the walk ends, the engine pulses `done` for one cycle. Alongside that pulse it gives set masks for the raw interrupt register and the DMA status register. After each descriptor it also reports the bytes moved, so that a shared transfer counter can be decremented.

Top module: `sd_desc_dma`

## Requirements
- R1: A descriptor at address D is read as four words in this fixed order: status at D+0, buffer size at D+4, buffer address at D+8 and next-descriptor address at D+12.
- R2: A buffer size word of 0 is taken as `MAX_DESC_BYTES` (default 8192).
- R3: A buffer size word above `MAX_DESC_BYTES` is clamped to `MAX_DESC_BYTES`.
- R4: A descriptor moves B bytes, where B is the smaller of its effective size and the remaining byte count. This takes ceil(B/4) words. `xfer_dec` pulses once per descriptor with `xfer_bytes` equal to B.
- R5: Bits 1:0 of the buffer address are ignored. The first word moved is at the address with those bits forced to zero, and each following word is at the next word address.
- R6: After its data has moved, each descriptor's status word is written back to D+0 with bit 31 (owned) cleared and all other bits kept.
- R7: The walk stops after a descriptor whose status bit 2 (last) is set, or when the remaining byte count reaches zero. Otherwise the next-address word is fetched as the next descriptor. Descriptors after the stop point are not touched.
- R8: `start` is acted on only when all of the following hold:
  - `byte_count` is nonzero;
  - `block_size` is nonzero;
  - `dma_en` is 1;
  - for a read, `card_ready` is 1.

  Otherwise nothing happens: no memory access, no `busy` and no `done`.
- R9: On completion `done` pulses once. In the same cycle `rawint_set` is 0x00010008 (bits 3 and 16) and `dmastat_set` has bit 8 set, plus bit 0 for a write (memory to card) or bit 1 for a read (card to memory).
- R10: A `start` that arrives while `busy` is 1 is ignored.
- R11: In write direction, memory words go out on the card port in address order. In read direction, card words are stored to memory in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse |
| dma_en | input | 1 | DMA enable from global control |
| dir_write | input | 1 | 1: memory to card, 0: card to memory |
| card_ready | input | 1 | Card reports data ready (read direction) |
| desc_base | input | 32 | Address of the first descriptor |
| byte_count | input | 32 | Total bytes to move |
| block_size | input | 32 | Block size; only checked for nonzero |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when 1, read when 0 |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory access completes |
| card_wvalid | output | 1 | Word offered to the card |
| card_wdata | output | 32 | Word to the card |
| card_wready | input | 1 | Card accepts the offered word |
| card_rready | output | 1 | Engine accepts a word from the card |
| card_rdata | input | 32 | Word from the card |
| card_rvalid | input | 1 | Card word is valid |
| busy | output | 1 | Walk in progress |
| xfer_dec | output | 1 | Pulse after each descriptor's writeback |
| xfer_bytes | output | 32 | Bytes moved by that descriptor |
| done | output | 1 | Completion pulse |
| rawint_set | output | 32 | Raw interrupt bits to set, valid with `done` |
| dmastat_set | output | 10 | DMA status bits to set, valid with `done` |

## Verification
The hardest case to reach is the size default and clamp. It takes a byte count larger than `MAX_DESC_BYTES`, so that the minimum with the remaining count does not hide the effect. The bench chains a size-0 descriptor to an oversize descriptor with a count of 20000 bytes. It then checks that each reported chunk is exactly 8192 bytes. Ending on an exhausted count is reached by giving descriptors no last flag and a count smaller than one buffer. The bench then checks that the second descriptor's owned bit survives.

// File: rtl/sddma_pkg.sv
package sddma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_MOVE,
    ST_WB,
    ST_DONE
  } dma_state_t;

  localparam int OWN_BIT       = 31;
  localparam int LAST_BIT      = 2;
  localparam int RAW_DATA_DONE = 3;
  localparam int RAW_CARD_EVT  = 16;
  localparam int DST_SUMMARY   = 8;
  localparam int DST_TX        = 0;
  localparam int DST_RX        = 1;
  localparam int DST_W         = 10;
endpackage

// File: rtl/sddma_len_calc.sv
module sddma_len_calc #(
  parameter int MAX_DESC_BYTES = 8192,
  parameter int CW             = 32
) (
  input  logic [31:0]   size_word,
  input  logic [CW-1:0] remain,
  output logic [CW-1:0] chunk_bytes,
  output logic [CW-1:0] chunk_words
);
  localparam logic [31:0] MAXB = 32'(MAX_DESC_BYTES);

  logic [31:0]   eff_size;
  logic [CW-1:0] eff_cw;

  always_comb begin
    if (size_word == 32'd0)     eff_size = MAXB;
    else if (size_word > MAXB)  eff_size = MAXB;
    else                        eff_size = size_word;
    eff_cw      = CW'(eff_size);
    chunk_bytes = (eff_cw < remain) ? eff_cw : remain;
    chunk_words = (chunk_bytes + CW'(3)) >> 2;
  end
endmodule

// File: rtl/sddma_ctrl.sv
module sddma_ctrl
  import sddma_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dma_en,
  input  logic          dir_write,
  input  logic          card_ready,
  input  logic [31:0]   desc_base,
  input  logic [CW-1:0] byte_count,
  input  logic [31:0]   block_size,
  output logic          mem_req,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  output logic          card_wvalid,
  output logic [31:0]   card_wdata,
  input  logic          card_wready,
  output logic          card_rready,
  input  logic [31:0]   card_rdata,
  input  logic          card_rvalid,
  output logic [31:0]   size_word,
  output logic [CW-1:0] remain,
  input  logic [CW-1:0] calc_bytes,
  input  logic [CW-1:0] calc_words,
  output logic          busy,
  output logic          xfer_dec,
  output logic [CW-1:0] xfer_bytes,
  output logic          done,
  output logic [31:0]   rawint_set,
  output logic [DST_W-1:0] dmastat_set
);
  dma_state_t    state_q, state_d;
  logic [1:0]    fidx_q, fidx_d;
  logic          phase_q, phase_d;
  logic          dir_q, dir_d;
  logic [31:0]   cur_q, cur_d;
  logic [CW-1:0] remain_q, remain_d;
  logic [CW-1:0] words_q, words_d;
  logic [CW-1:0] bytes_q, bytes_d;
  logic [31:0]   baddr_q, baddr_d;
  logic [31:0]   stat_q, stat_d;
  logic [31:0]   size_q, size_d;
  logic [31:0]   next_q, next_d;
  logic [31:0]   dbuf_q, dbuf_d;
  logic          step;
  logic          go;

  assign size_word = size_q;
  assign remain    = remain_q;

  always_comb begin
    go = start && (byte_count != '0) && (block_size != 32'd0) && dma_en &&
         (dir_write || card_ready);
  end

  always_comb begin
    state_d  = state_q;
    fidx_d   = fidx_q;
    phase_d  = phase_q;
    dir_d    = dir_q;
    cur_d    = cur_q;
    remain_d = remain_q;
    words_d  = words_q;
    bytes_d  = bytes_q;
    baddr_d  = baddr_q;
    stat_d   = stat_q;
    size_d   = size_q;
    next_d   = next_q;
    dbuf_d   = dbuf_q;
    step        = 1'b0;
    mem_req     = 1'b0;
    mem_we      = 1'b0;
    mem_addr    = cur_q;
    mem_wdata   = 32'd0;
    card_wvalid = 1'b0;
    card_wdata  = dbuf_q;
    card_rready = 1'b0;
    xfer_dec    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (go) begin
          state_d  = ST_FETCH;
          fidx_d   = 2'd0;
          cur_d    = desc_base;
          remain_d = byte_count;
          dir_d    = dir_write;
        end
      end
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = cur_q + {28'd0, fidx_q, 2'b00};
        if (mem_ack) begin
          case (fidx_q)
            2'd0: stat_d  = mem_rdata;
            2'd1: size_d  = mem_rdata;
            2'd2: baddr_d = {mem_rdata[31:2], 2'b00};
            default: next_d = mem_rdata;
          endcase
          fidx_d = fidx_q + 2'd1;
          if (fidx_q == 2'd3) begin
            state_d = ST_MOVE;
            phase_d = 1'b0;
            bytes_d = calc_bytes;
            words_d = calc_words;
          end
        end
      end
      ST_MOVE: begin
        if (dir_q) begin
          if (!phase_q) begin
            mem_req  = 1'b1;
            mem_addr = baddr_q;
            if (mem_ack) begin
              dbuf_d  = mem_rdata;
              phase_d = 1'b1;
            end
          end else begin
            card_wvalid = 1'b1;
            step        = card_wready;
          end
        end else begin
          if (!phase_q) begin
            card_rready = 1'b1;
            if (card_rvalid) begin
              dbuf_d  = card_rdata;
              phase_d = 1'b1;
            end
          end else begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = baddr_q;
            mem_wdata = dbuf_q;
            step      = mem_ack;
          end
        end
        if (step) begin
          baddr_d = baddr_q + 32'd4;
          words_d = words_q - CW'(1);
          phase_d = 1'b0;
          if (words_q == CW'(1)) state_d = ST_WB;
        end
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_q;
        mem_wdata = stat_q & ~(32'd1 << OWN_BIT);
        if (mem_ack) begin
          xfer_dec = 1'b1;
          remain_d = remain_q - bytes_q;
          if (stat_q[LAST_BIT] || (remain_q == bytes_q)) begin
            state_d = ST_DONE;
          end else begin
            cur_d   = next_q;
            fidx_d  = 2'd0;
            state_d = ST_FETCH;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      fidx_q   <= 2'd0;
      phase_q  <= 1'b0;
      dir_q    <= 1'b0;
      cur_q    <= 32'd0;
      remain_q <= '0;
      words_q  <= '0;
      bytes_q  <= '0;
      baddr_q  <= 32'd0;
      stat_q   <= 32'd0;
      size_q   <= 32'd0;
      next_q   <= 32'd0;
      dbuf_q   <= 32'd0;
    end else begin
      state_q  <= state_d;
      fidx_q   <= fidx_d;
      phase_q  <= phase_d;
      dir_q    <= dir_d;
      cur_q    <= cur_d;
      remain_q <= remain_d;
      words_q  <= words_d;
      bytes_q  <= bytes_d;
      baddr_q  <= baddr_d;
      stat_q   <= stat_d;
      size_q   <= size_d;
      next_q   <= next_d;
      dbuf_q   <= dbuf_d;
    end
  end

  always_comb begin
    busy        = (state_q != ST_IDLE);
    done        = (state_q == ST_DONE);
    xfer_bytes  = bytes_q;
    rawint_set  = 32'd0;
    dmastat_set = '0;
    if (done) begin
      rawint_set[RAW_DATA_DONE] = 1'b1;
      rawint_set[RAW_CARD_EVT]  = 1'b1;
      dmastat_set[DST_SUMMARY]  = 1'b1;
      if (dir_q) dmastat_set[DST_TX] = 1'b1;
      else       dmastat_set[DST_RX] = 1'b1;
    end
  end
endmodule

// File: rtl/sd_desc_dma.sv
module sd_desc_dma
  import sddma_pkg::*;
#(
  parameter int MAX_DESC_BYTES = 8192,
  parameter int CW             = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dma_en,
  input  logic              dir_write,
  input  logic              card_ready,
  input  logic [31:0]       desc_base,
  input  logic [CW-1:0]     byte_count,
  input  logic [31:0]       block_size,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              card_wvalid,
  output logic [31:0]       card_wdata,
  input  logic              card_wready,
  output logic              card_rready,
  input  logic [31:0]       card_rdata,
  input  logic              card_rvalid,
  output logic              busy,
  output logic              xfer_dec,
  output logic [CW-1:0]     xfer_bytes,
  output logic              done,
  output logic [31:0]       rawint_set,
  output logic [DST_W-1:0]  dmastat_set
);
  logic [31:0]   size_word;
  logic [CW-1:0] remain;
  logic [CW-1:0] calc_bytes;
  logic [CW-1:0] calc_words;

  sddma_len_calc #(.MAX_DESC_BYTES(MAX_DESC_BYTES), .CW(CW)) u_len (
    .size_word   (size_word),
    .remain      (remain),
    .chunk_bytes (calc_bytes),
    .chunk_words (calc_words)
  );

  sddma_ctrl #(.CW(CW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .dma_en      (dma_en),
    .dir_write   (dir_write),
    .card_ready  (card_ready),
    .desc_base   (desc_base),
    .byte_count  (byte_count),
    .block_size  (block_size),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .mem_ack     (mem_ack),
    .card_wvalid (card_wvalid),
    .card_wdata  (card_wdata),
    .card_wready (card_wready),
    .card_rready (card_rready),
    .card_rdata  (card_rdata),
    .card_rvalid (card_rvalid),
    .size_word   (size_word),
    .remain      (remain),
    .calc_bytes  (calc_bytes),
    .calc_words  (calc_words),
    .busy        (busy),
    .xfer_dec    (xfer_dec),
    .xfer_bytes  (xfer_bytes),
    .done        (done),
    .rawint_set  (rawint_set),
    .dmastat_set (dmastat_set)
  );
endmodule

// File: rtl/sddma_checks.sv
module sddma_checks #(
  parameter int MAX_DESC_BYTES = 8192,
  parameter int CW             = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          dma_en,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_addr_lo1,
  input logic          mem_addr_lo0,
  input logic          card_wvalid,
  input logic          card_rready,
  input logic          xfer_dec,
  input logic [CW-1:0] xfer_bytes,
  input logic          done,
  input logic [31:0]   rawint_set,
  input logic [9:0]    dmastat_set
);
  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R8
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (!mem_addr_lo1 && !mem_addr_lo0)); // R5
  AST_GATED_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !dma_en) |=> !busy); // R8
  AST_CHUNK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_dec |-> (xfer_bytes != '0 && xfer_bytes <= CW'(MAX_DESC_BYTES))); // R4
  AST_RAW_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rawint_set == 32'h0001_0008); // R9
  AST_DIR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (dmastat_set[8] && $countones(dmastat_set[1:0]) == 1)); // R9
  AST_NO_FLAGS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (rawint_set == 32'd0 && dmastat_set == 10'd0)); // R9
  AST_CARD_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    !(card_wvalid && card_rready)); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
endmodule

bind sd_desc_dma sddma_checks #(.MAX_DESC_BYTES(MAX_DESC_BYTES), .CW(CW)) u_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .dma_en       (dma_en),
  .busy         (busy),
  .mem_req      (mem_req),
  .mem_addr_lo1 (mem_addr[1]),
  .mem_addr_lo0 (mem_addr[0]),
  .card_wvalid  (card_wvalid),
  .card_rready  (card_rready),
  .xfer_dec     (xfer_dec),
  .xfer_bytes   (xfer_bytes),
  .done         (done),
  .rawint_set   (rawint_set),
  .dmastat_set  (dmastat_set)
);

// File: tb/tb_sd_desc_dma.sv
`timescale 1ns/1ps
module tb_sd_desc_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, dma_en = 1'b0, dir_write = 1'b0, card_ready = 1'b0;
  logic [31:0] desc_base = 32'd0, byte_count = 32'd0, block_size = 32'd0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        card_wvalid, card_wready, card_rready, card_rvalid;
  logic [31:0] card_wdata, card_rdata;
  logic        busy, xfer_dec, done;
  logic [31:0] xfer_bytes, rawint_set;
  logic [9:0]  dmastat_set;

  logic [31:0] mem [0:4095];
  logic [31:0] cap [0:8191];
  logic [31:0] xl  [0:63];
  int cap_n = 0, rd_cnt = 0, xn = 0, done_n = 0, req_n = 0;
  logic [31:0] last_raw = 32'd0;
  logic [9:0]  last_dst = 10'd0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  sd_desc_dma dut (.*);

  assign mem_ack     = mem_req;
  assign mem_rdata   = mem[mem_addr[13:2]];
  assign card_wready = 1'b1;
  assign card_rvalid = 1'b1;
  assign card_rdata  = 32'hC0DE0000 | 32'(rd_cnt);

  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_we) mem[mem_addr[13:2]] <= mem_wdata;
      if (card_wvalid && card_wready) begin cap[cap_n] <= card_wdata; cap_n <= cap_n + 1; end
      if (card_rready && card_rvalid) rd_cnt <= rd_cnt + 1;
      if (xfer_dec) begin xl[xn] <= xfer_bytes; xn <= xn + 1; end
      if (mem_req) req_n <= req_n + 1;
      if (done) begin done_n <= done_n + 1; last_raw <= rawint_set; last_dst <= dmastat_set; end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put_desc(input int a, input logic [31:0] st, sz, ba, nx);
    mem[a/4] = st; mem[a/4+1] = sz; mem[a/4+2] = ba; mem[a/4+3] = nx;
  endtask

  task automatic launch(input logic [31:0] base, cnt, input logic wr);
    int d0;
    d0 = done_n;
    @(negedge clk);
    desc_base = base; byte_count = cnt; block_size = 32'd512;
    dir_write = wr; dma_en = 1'b1; card_ready = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (done_n == d0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R8 reset busy", 32'(busy), 32'd0);
    chk("R8 reset req", 32'(mem_req), 32'd0);
    chk("R9 reset done", 32'(done), 32'd0);
  endtask

  task automatic t_write_single();
    int c0, x0;
    put_desc(32'h000, 32'h8000000C, 32'd16, 32'h100, 32'h0);
    for (int i = 0; i < 4; i++) mem[32'h100/4 + i] = 32'hA000 + 32'(i);
    c0 = cap_n; x0 = xn;
    launch(32'h000, 32'd16, 1'b1);
    chk("R1 R11 write word count", 32'(cap_n - c0), 32'd4);
    for (int i = 0; i < 4; i++) chk("R11 write data order", cap[c0+i], 32'hA000 + 32'(i));
    chk("R6 writeback owned cleared", mem[0], 32'h0000000C);
    chk("R4 chunk bytes", xl[x0], 32'd16);
    chk("R9 raw flags", last_raw, 32'h00010008);
    chk("R9 write status flags", 32'(last_dst), 32'h101);
  endtask

  task automatic t_read_chain();
    int r0, x0;
    put_desc(32'h040, 32'h80000018, 32'd8, 32'h300, 32'h060);
    put_desc(32'h060, 32'h80000014, 32'd8, 32'h380, 32'h0);
    r0 = rd_cnt; x0 = xn;
    launch(32'h040, 32'd16, 1'b0);
    chk("R11 read word0", mem[32'h300/4],   32'hC0DE0000 | 32'(r0));
    chk("R11 read word1", mem[32'h300/4+1], 32'hC0DE0000 | 32'(r0+1));
    chk("R7 chained word2", mem[32'h380/4], 32'hC0DE0000 | 32'(r0+2));
    chk("R7 chained word3", mem[32'h380/4+1], 32'hC0DE0000 | 32'(r0+3));
    chk("R6 wb first", mem[32'h040/4], 32'h00000018);
    chk("R6 wb second", mem[32'h060/4], 32'h00000014);
    chk("R4 chunks", 32'(xn - x0), 32'd2);
    chk("R9 read status flags", 32'(last_dst), 32'h102);
  endtask

  task automatic t_count_stop();
    int c0, x0;
    put_desc(32'h080, 32'h80000000, 32'd16, 32'h400, 32'h0A0);
    put_desc(32'h0A0, 32'h80000000, 32'd16, 32'h400, 32'h0);
    c0 = cap_n; x0 = xn;
    launch(32'h080, 32'd8, 1'b1);
    chk("R7 count stop words", 32'(cap_n - c0), 32'd2);
    chk("R4 min bytes", xl[x0], 32'd8);
    chk("R6 wb cleared", mem[32'h080/4], 32'h0);
    chk("R7 next untouched", mem[32'h0A0/4], 32'h80000000);
  endtask

  task automatic t_odd();
    int c0, x0;
    put_desc(32'h0C0, 32'h80000004, 32'd16, 32'h400, 32'h0);
    c0 = cap_n; x0 = xn;
    launch(32'h0C0, 32'd6, 1'b1);
    chk("R4 ceil words", 32'(cap_n - c0), 32'd2);
    chk("R4 odd bytes", xl[x0], 32'd6);
  endtask

  task automatic t_align();
    int c0;
    put_desc(32'h0E0, 32'h80000004, 32'd8, 32'h503, 32'h0);
    mem[32'h500/4] = 32'h5555AAAA; mem[32'h504/4] = 32'h12345678;
    c0 = cap_n;
    launch(32'h0E0, 32'd8, 1'b1);
    chk("R5 aligned first", cap[c0], 32'h5555AAAA);
    chk("R5 aligned second", cap[c0+1], 32'h12345678);
  endtask

  task automatic t_size_limits();
    int c0, x0;
    put_desc(32'h600, 32'h80000000, 32'd0, 32'h1000, 32'h620);
    put_desc(32'h620, 32'h80000004, 32'h10000, 32'h1000, 32'h0);
    c0 = cap_n; x0 = xn;
    launch(32'h600, 32'd20000, 1'b1);
    chk("R2 zero size is max", xl[x0], 32'd8192);
    chk("R3 oversize clamped", xl[x0+1], 32'd8192);
    chk("R3 total words", 32'(cap_n - c0), 32'd4096);
  endtask

  task automatic gate_try(input string tag, input logic en, input logic [31:0] cnt,
                          input logic [31:0] bs, input logic wr, input logic rdy);
    int d0, q0;
    d0 = done_n; q0 = req_n;
    @(negedge clk);
    desc_base = 32'h000; byte_count = cnt; block_size = bs;
    dma_en = en; dir_write = wr; card_ready = rdy; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " busy"}, 32'(busy), 32'd0);
    repeat (5) @(negedge clk);
    chk({tag, " no access"}, 32'(req_n - q0), 32'd0);
    chk({tag, " no done"}, 32'(done_n - d0), 32'd0);
  endtask

  task automatic t_gate();
    put_desc(32'h000, 32'h8000000C, 32'd16, 32'h100, 32'h0);
    gate_try("R8 disabled", 1'b0, 32'd16, 32'd512, 1'b1, 1'b1);
    gate_try("R8 zero block", 1'b1, 32'd16, 32'd0, 1'b1, 1'b1);
    gate_try("R8 zero count", 1'b1, 32'd0, 32'd512, 1'b1, 1'b1);
    gate_try("R8 card not ready", 1'b1, 32'd16, 32'd512, 1'b0, 1'b0);
    chk("R8 descriptor untouched", mem[0], 32'h8000000C);
  endtask

  task automatic t_busy_start();
    int d0;
    put_desc(32'h000, 32'h8000000C, 32'd16, 32'h100, 32'h0);
    put_desc(32'h080, 32'h80000004, 32'd16, 32'h400, 32'h0);
    d0 = done_n;
    @(negedge clk);
    desc_base = 32'h000; byte_count = 32'd16; block_size = 32'd512;
    dir_write = 1'b1; dma_en = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    desc_base = 32'h080; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);
    chk("R10 one completion", 32'(done_n - d0), 32'd1);
    chk("R10 second desc untouched", mem[32'h080/4], 32'h80000004);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_single();
    t_read_chain();
    t_count_stop();
    t_odd();
    t_align();
    t_size_limits();
    t_gate();
    t_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule